// File: doc/BRIEF.md
# Radix-4 Complex Butterfly Node

This block is the four-point arithmetic core of a fixed-point inverse FFT stage. It has no clock and no state. It takes four complex samples and four complex twiddle factors, multiplies each sample by its own twiddle, and then combines the four products in two add/subtract layers. The first layer rotates one difference by the imaginary unit. The results are four complex values, available in the same cycle as the inputs.

Every value is a signed Q1.15 pair: a real half and an imaginary half. Each half is carried in a flat vector with one slice per lane, and lane n occupies bits `[16n+15:16n]`. Twiddle generation, the permutation between stages, saturation and registering are left to the surrounding stage.

The parameter `UNITY_TW0` covers algorithm variants in which the first twiddle is always one. When it is set, the lane-0 multiplier is not built and the first twiddle inputs are ignored.

Top module: `radix4_bfly`

## Requirements
- R1: Each product m[n] = t[n]·k[n] is formed as re = (tr·kr − ti·ki), im = (tr·ki + ti·kr). The two partial products are 32-bit signed values and are combined modulo 2^32. The result is then arithmetically shifted right by 15, and its low 16 bits are kept.
- R2: The first combining layer forms y0 = m0+m2, y1 = m0−m2 and y2 = m1+m3.
- R3: y3 is (m1−m3) multiplied by i: real part = −(imag of the difference), imag part = real of the difference. No multiplier is used for this rotation.
- R4: The outputs are z0 = y0+y2, z1 = y1+y3, z2 = y0−y2 and z3 = y1−y3. Output zn is placed on lane n, at bits [16n+15:16n] of both `z_re_o` and `z_im_o`.
- R5: Every add, subtract and negate wraps modulo 2^16 with no saturation.
- R6: With UNITY_TW0=1, m0 equals t0. The lane-0 twiddle inputs have no effect on any output.
- R7: The outputs are a pure combinational function of the present inputs. There is no clock, no reset and no latency.
- R8: The product (−1)·(−1) = +1.0, which cannot be represented, wraps to −32768 in the product's 16-bit result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| samp_re_i | input | 4*DATA_W | Real parts of samples t0..t3, lane n at [n*DATA_W +: DATA_W] |
| samp_im_i | input | 4*DATA_W | Imaginary parts of samples t0..t3 |
| tw_re_i | input | 4*DATA_W | Real parts of twiddles k0..k3 |
| tw_im_i | input | 4*DATA_W | Imaginary parts of twiddles k0..k3 |
| z_re_o | output | 4*DATA_W | Real parts of results z0..z3 |
| z_im_o | output | 4*DATA_W | Imaginary parts of results z0..z3 |

## Verification
The bench builds two instances side by side on the same stimulus: one with UNITY_TW0=0 and one with UNITY_TW0=1. Both use DATA_W=16 and FRAC_W=15. The pair makes it possible to compare the full four-multiplier datapath and the bypassed lane on identical vectors. It also makes it possible to show that a change to the first twiddle alone moves only the first instance's outputs. The 16-bit width allows directed corner vectors at the most negative code, where the product overflows and every sum wraps. These directed vectors are mixed with random vectors.

// File: rtl/radix4_bfly_pkg.sv
package radix4_bfly_pkg;
  parameter int unsigned BFLY_LANES = 4;
  // lane pairing for the first combining layer
  parameter int unsigned EVEN_A = 0;
  parameter int unsigned EVEN_B = 2;
  parameter int unsigned ODD_A  = 1;
  parameter int unsigned ODD_B  = 3;
endpackage

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 15
) (
  input  logic signed [DATA_W-1:0] a_re_i,
  input  logic signed [DATA_W-1:0] a_im_i,
  input  logic signed [DATA_W-1:0] b_re_i,
  input  logic signed [DATA_W-1:0] b_im_i,
  output logic signed [DATA_W-1:0] p_re_o,
  output logic signed [DATA_W-1:0] p_im_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned TOP_W  = PROD_W - DATA_W - FRAC_W;

  logic signed [PROD_W-1:0] prod_rr, prod_ii, prod_ri, prod_ir;
  logic signed [PROD_W-1:0] acc_re, acc_im;

  assign prod_rr = a_re_i * b_re_i;
  assign prod_ii = a_im_i * b_im_i;
  assign prod_ri = a_re_i * b_im_i;
  assign prod_ir = a_im_i * b_re_i;

  assign acc_re = prod_rr - prod_ii;
  assign acc_im = prod_ri + prod_ir;

  // shift by FRAC_W and truncate: a plain slice
  assign p_re_o = acc_re[FRAC_W +: DATA_W];
  assign p_im_o = acc_im[FRAC_W +: DATA_W];

  logic unused_bits;
  assign unused_bits = ^{acc_re[PROD_W-1 -: TOP_W], acc_re[FRAC_W-1:0],
                         acc_im[PROD_W-1 -: TOP_W], acc_im[FRAC_W-1:0]};
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_re_i,
  input  logic [DATA_W-1:0] a_im_i,
  input  logic [DATA_W-1:0] b_re_i,
  input  logic [DATA_W-1:0] b_im_i,
  output logic [DATA_W-1:0] s_re_o,
  output logic [DATA_W-1:0] s_im_o,
  output logic [DATA_W-1:0] d_re_o,
  output logic [DATA_W-1:0] d_im_o
);
  assign s_re_o = a_re_i + b_re_i;
  assign s_im_o = a_im_i + b_im_i;
  assign d_re_o = a_re_i - b_re_i;
  assign d_im_o = a_im_i - b_im_i;
endmodule

// File: rtl/radix4_bfly.sv
module radix4_bfly #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FRAC_W    = 15,
  parameter bit          UNITY_TW0 = 1'b0
) (
  input  logic [radix4_bfly_pkg::BFLY_LANES*DATA_W-1:0] samp_re_i,
  input  logic [radix4_bfly_pkg::BFLY_LANES*DATA_W-1:0] samp_im_i,
  input  logic [radix4_bfly_pkg::BFLY_LANES*DATA_W-1:0] tw_re_i,
  input  logic [radix4_bfly_pkg::BFLY_LANES*DATA_W-1:0] tw_im_i,
  output logic [radix4_bfly_pkg::BFLY_LANES*DATA_W-1:0] z_re_o,
  output logic [radix4_bfly_pkg::BFLY_LANES*DATA_W-1:0] z_im_o
);
  import radix4_bfly_pkg::*;
  localparam int unsigned LANES = BFLY_LANES;
  localparam int unsigned VEC_W = LANES * DATA_W;

  logic [VEC_W-1:0] m_re, m_im;
  logic [VEC_W-1:0] y_re, y_im;
  logic [DATA_W-1:0] odd_d_re, odd_d_im;

  // product layer
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    if (n == 0 && UNITY_TW0) begin : g_unity
      assign m_re[n*DATA_W +: DATA_W] = samp_re_i[n*DATA_W +: DATA_W];
      assign m_im[n*DATA_W +: DATA_W] = samp_im_i[n*DATA_W +: DATA_W];
      logic unused_tw0;
      assign unused_tw0 = ^{tw_re_i[n*DATA_W +: DATA_W], tw_im_i[n*DATA_W +: DATA_W]};
    end else begin : g_mult
      bfly_cmul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_cmul (
        .a_re_i (samp_re_i[n*DATA_W +: DATA_W]),
        .a_im_i (samp_im_i[n*DATA_W +: DATA_W]),
        .b_re_i (tw_re_i[n*DATA_W +: DATA_W]),
        .b_im_i (tw_im_i[n*DATA_W +: DATA_W]),
        .p_re_o (m_re[n*DATA_W +: DATA_W]),
        .p_im_o (m_im[n*DATA_W +: DATA_W])
      );
    end
  end

  // first combining layer: even pair -> y0,y1 ; odd pair -> y2, diff
  bfly_addsub #(.DATA_W(DATA_W)) u_even (
    .a_re_i (m_re[EVEN_A*DATA_W +: DATA_W]),
    .a_im_i (m_im[EVEN_A*DATA_W +: DATA_W]),
    .b_re_i (m_re[EVEN_B*DATA_W +: DATA_W]),
    .b_im_i (m_im[EVEN_B*DATA_W +: DATA_W]),
    .s_re_o (y_re[0*DATA_W +: DATA_W]),
    .s_im_o (y_im[0*DATA_W +: DATA_W]),
    .d_re_o (y_re[1*DATA_W +: DATA_W]),
    .d_im_o (y_im[1*DATA_W +: DATA_W])
  );

  bfly_addsub #(.DATA_W(DATA_W)) u_odd (
    .a_re_i (m_re[ODD_A*DATA_W +: DATA_W]),
    .a_im_i (m_im[ODD_A*DATA_W +: DATA_W]),
    .b_re_i (m_re[ODD_B*DATA_W +: DATA_W]),
    .b_im_i (m_im[ODD_B*DATA_W +: DATA_W]),
    .s_re_o (y_re[2*DATA_W +: DATA_W]),
    .s_im_o (y_im[2*DATA_W +: DATA_W]),
    .d_re_o (odd_d_re),
    .d_im_o (odd_d_im)
  );

  // multiply by i: swap halves, negate the new real part
  assign y_re[3*DATA_W +: DATA_W] = -odd_d_im;
  assign y_im[3*DATA_W +: DATA_W] = odd_d_re;

  // second combining layer: (y0,y2) -> z0,z2 ; (y1,y3) -> z1,z3
  bfly_addsub #(.DATA_W(DATA_W)) u_out_a (
    .a_re_i (y_re[0*DATA_W +: DATA_W]),
    .a_im_i (y_im[0*DATA_W +: DATA_W]),
    .b_re_i (y_re[2*DATA_W +: DATA_W]),
    .b_im_i (y_im[2*DATA_W +: DATA_W]),
    .s_re_o (z_re_o[0*DATA_W +: DATA_W]),
    .s_im_o (z_im_o[0*DATA_W +: DATA_W]),
    .d_re_o (z_re_o[2*DATA_W +: DATA_W]),
    .d_im_o (z_im_o[2*DATA_W +: DATA_W])
  );

  bfly_addsub #(.DATA_W(DATA_W)) u_out_b (
    .a_re_i (y_re[1*DATA_W +: DATA_W]),
    .a_im_i (y_im[1*DATA_W +: DATA_W]),
    .b_re_i (y_re[3*DATA_W +: DATA_W]),
    .b_im_i (y_im[3*DATA_W +: DATA_W]),
    .s_re_o (z_re_o[1*DATA_W +: DATA_W]),
    .s_im_o (z_im_o[1*DATA_W +: DATA_W]),
    .d_re_o (z_re_o[3*DATA_W +: DATA_W]),
    .d_im_o (z_im_o[3*DATA_W +: DATA_W])
  );
endmodule

// File: rtl/radix4_bfly_chk.sv
module radix4_bfly_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter bit          UNITY_TW0 = 1'b0
) (
  input logic [4*DATA_W-1:0] samp_re,
  input logic [4*DATA_W-1:0] samp_im,
  input logic [4*DATA_W-1:0] m_re,
  input logic [4*DATA_W-1:0] m_im,
  input logic [4*DATA_W-1:0] y_re,
  input logic [4*DATA_W-1:0] y_im,
  input logic [4*DATA_W-1:0] z_re,
  input logic [4*DATA_W-1:0] z_im
);
  function automatic logic [DATA_W-1:0] ln(input logic [4*DATA_W-1:0] v, input int n);
    return v[n*DATA_W +: DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] dbl(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], 1'b0};
  endfunction

  logic [DATA_W-1:0] s02_re, s02_im, s13_re, s13_im, sy_re, sy_im;
  logic [DATA_W-1:0] odd_re, odd_im, tot_re, tot_im;

  always_comb begin
    s02_re = ln(z_re, 0) + ln(z_re, 2);
    s02_im = ln(z_im, 0) + ln(z_im, 2);
    s13_re = ln(z_re, 1) + ln(z_re, 3);
    s13_im = ln(z_im, 1) + ln(z_im, 3);
    sy_re  = ln(y_re, 0) + ln(y_re, 1);
    sy_im  = ln(y_im, 0) + ln(y_im, 1);
    odd_re = ln(y_re, 2) + ln(y_im, 3);
    odd_im = ln(y_im, 2) - ln(y_re, 3);
    tot_re = s02_re + s13_re;
    tot_im = s02_im + s13_im;

    // R4: output pairs recombine to twice the first-layer values
    assert_out_pairs_R4: assert (s02_re == dbl(ln(y_re, 0)) && s02_im == dbl(ln(y_im, 0)) &&
                                 s13_re == dbl(ln(y_re, 1)) && s13_im == dbl(ln(y_im, 1)))
      else $error("R4 output pair mismatch");
    // R2: y0 + y1 returns twice m0
    assert_even_pair_R2: assert (sy_re == dbl(ln(m_re, 0)) && sy_im == dbl(ln(m_im, 0)))
      else $error("R2 even pair mismatch");
    // R3: undoing the rotation of y3 against y2 gives twice m1
    assert_rotation_R3: assert (odd_re == dbl(ln(m_re, 1)) && odd_im == dbl(ln(m_im, 1)))
      else $error("R3 rotation mismatch");
    // R5: all four outputs sum to 4*m0 under wrapping arithmetic
    assert_wrap_total_R5: assert (tot_re == {ln(m_re, 0)[DATA_W-3:0], 2'b00} &&
                                  tot_im == {ln(m_im, 0)[DATA_W-3:0], 2'b00})
      else $error("R5 total mismatch");
    // R6: unity mode, output total is 4*t0
    if (UNITY_TW0) begin
      assert_unity_R6: assert (tot_re == {ln(samp_re, 0)[DATA_W-3:0], 2'b00} &&
                               tot_im == {ln(samp_im, 0)[DATA_W-3:0], 2'b00})
        else $error("R6 unity lane mismatch");
    end
  end
endmodule

bind radix4_bfly radix4_bfly_chk #(.DATA_W(DATA_W), .UNITY_TW0(UNITY_TW0)) u_chk (
  .samp_re (samp_re_i),
  .samp_im (samp_im_i),
  .m_re    (m_re),
  .m_im    (m_im),
  .y_re    (y_re),
  .y_im    (y_im),
  .z_re    (z_re_o),
  .z_im    (z_im_o)
);

// File: tb/tb_radix4_bfly.sv
module tb_radix4_bfly;
  localparam int W = 16;
  localparam int L = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [L*W-1:0] s_re, s_im, w_re, w_im;
  logic [L*W-1:0] z_re, z_im, zu_re, zu_im;

  radix4_bfly #(.DATA_W(W), .FRAC_W(15), .UNITY_TW0(1'b0)) dut (
    .samp_re_i(s_re), .samp_im_i(s_im), .tw_re_i(w_re), .tw_im_i(w_im),
    .z_re_o(z_re), .z_im_o(z_im));

  radix4_bfly #(.DATA_W(W), .FRAC_W(15), .UNITY_TW0(1'b1)) dut_u (
    .samp_re_i(s_re), .samp_im_i(s_im), .tw_re_i(w_re), .tw_im_i(w_im),
    .z_re_o(zu_re), .z_im_o(zu_im));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int sr[L], si[L], wr[L], wi[L];
  logic [L*W-1:0] e_re, e_im;

  function automatic int qprod(int a, int b, int c, int d);
    longint p;
    logic [31:0] p32;
    p = longint'(a) * longint'(b) - longint'(c) * longint'(d);
    p32 = p[31:0];
    return int'({16'h0, p32[30:15]});
  endfunction

  task automatic ref_calc(input bit unity);
    int mr[L], mi[L];
    int y0r, y0i, y1r, y1i, y2r, y2i, y3r, y3i, dr, di;
    int zr[L], zi[L];
    for (int n = 0; n < L; n++) begin
      if (n == 0 && unity) begin
        mr[n] = sr[n]; mi[n] = si[n];
      end else begin
        mr[n] = qprod(sr[n], wr[n], si[n], wi[n]);
        mi[n] = qprod(sr[n], wi[n], -si[n], wr[n]);
      end
    end
    y0r = mr[0] + mr[2]; y0i = mi[0] + mi[2];
    y1r = mr[0] - mr[2]; y1i = mi[0] - mi[2];
    y2r = mr[1] + mr[3]; y2i = mi[1] + mi[3];
    dr = mr[1] - mr[3];  di = mi[1] - mi[3];
    y3r = -di; y3i = dr;
    zr[0] = y0r + y2r; zi[0] = y0i + y2i;
    zr[1] = y1r + y3r; zi[1] = y1i + y3i;
    zr[2] = y0r - y2r; zi[2] = y0i - y2i;
    zr[3] = y1r - y3r; zi[3] = y1i - y3i;
    for (int n = 0; n < L; n++) begin
      e_re[n*W +: W] = zr[n][W-1:0];
      e_im[n*W +: W] = zi[n][W-1:0];
    end
  endtask

  task automatic drive();
    @(negedge clk);
    for (int n = 0; n < L; n++) begin
      s_re[n*W +: W] = sr[n][W-1:0];
      s_im[n*W +: W] = si[n][W-1:0];
      w_re[n*W +: W] = wr[n][W-1:0];
      w_im[n*W +: W] = wi[n][W-1:0];
    end
    #1;
  endtask

  task automatic cmp(input string tag, input logic [L*W-1:0] gr, gi, xr, xi);
    checks++;
    if (gr !== xr || gi !== xi) begin
      errors++;
      $display("FAIL %s: got re=%h im=%h expected re=%h im=%h", tag, gr, gi, xr, xi);
    end
  endtask

  task automatic check_both(input string tag);
    ref_calc(1'b0);
    cmp({tag, " mult"}, z_re, z_im, e_re, e_im);
    ref_calc(1'b1);
    cmp({tag, " unity"}, zu_re, zu_im, e_re, e_im);
  endtask

  task automatic clear();
    for (int n = 0; n < L; n++) begin
      sr[n] = 0; si[n] = 0; wr[n] = 0; wi[n] = 0;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    s_re = '0; s_im = '0; w_re = '0; w_im = '0;
    clear();

    // R7: zero inputs give zero outputs with no clock edge involved
    drive();
    cmp("R7 zero", z_re, z_im, '0, '0);
    cmp("R7 zero unity", zu_re, zu_im, '0, '0);

    // R1 R4: single sample on lane 0, twiddle near +1
    clear(); sr[0] = 16384; for (int n = 0; n < L; n++) wr[n] = 32767;
    drive(); check_both("R1 R4 lane0");

    // R3: lane 1 only, imaginary sample -> rotation shows on z1/z3
    clear(); si[1] = 8192; for (int n = 0; n < L; n++) wr[n] = 32767;
    drive(); check_both("R3 lane1");

    // R2: lane 2 only, complex twiddle
    clear(); sr[2] = 12000; si[2] = -7000; wr[2] = 23170; wi[2] = -23170;
    drive(); check_both("R2 lane2");

    // R8: (-1)*(-1) wraps to -32768 on every lane
    clear(); for (int n = 0; n < L; n++) begin sr[n] = -32768; wr[n] = -32768; end
    drive(); check_both("R8 minus one");
    // all-lane sum of four -32768 products is 0 modulo 2^16 on z0; explicit value
    cmp("R8 z0 value", {z_re[4*W-1:W], z_re[W-1:0]}, z_im,
        {e_re[4*W-1:W], 16'h0000}, '0);

    // R5: near full-scale products overflow the sums
    clear(); for (int n = 0; n < L; n++) begin sr[n] = 32767; si[n] = 32767; wr[n] = 32767; end
    drive(); check_both("R5 wrap");

    // R6: change only the lane-0 twiddle; unity instance must not move
    for (int v = 0; v < 20; v++) begin
      logic [L*W-1:0] hold_re, hold_im;
      for (int n = 0; n < L; n++) begin
        sr[n] = int'($urandom_range(65535)) - 32768; si[n] = int'($urandom_range(65535)) - 32768;
        wr[n] = int'($urandom_range(65535)) - 32768; wi[n] = int'($urandom_range(65535)) - 32768;
      end
      drive(); check_both("R6 base");
      hold_re = zu_re; hold_im = zu_im;
      wr[0] = int'($urandom_range(65535)) - 32768; wi[0] = int'($urandom_range(65535)) - 32768;
      drive();
      cmp("R6 tw0 ignored", zu_re, zu_im, hold_re, hold_im);
      ref_calc(1'b0);
      cmp("R6 mult tracks tw0", z_re, z_im, e_re, e_im);
    end

    // R1 R2 R3 R4 R5 R7: random vectors
    for (int v = 0; v < 400; v++) begin
      for (int n = 0; n < L; n++) begin
        sr[n] = int'($urandom_range(65535)) - 32768; si[n] = int'($urandom_range(65535)) - 32768;
        wr[n] = int'($urandom_range(65535)) - 32768; wi[n] = int'($urandom_range(65535)) - 32768;
      end
      drive(); check_both("R1 R2 R3 R4 R5 R7 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule